// File: doc/BRIEF.md
# OTP Calibration Store with Serial Shadow Loader

This block models a one-time-programmable calibration store. It has `NBITS` fuse cells. The lowest cell, bit 0, is a seal. The store is written through a shadow shift register that holds one cell per fuse. Software powers the block up and waits a settling delay. It then requests calibration mode and streams `NBITS` bits into the shadow register, most significant bit first. The seal bit is always the last bit streamed. A single-cycle program strobe stands in for the programming voltage. It sets every fuse whose shadow cell holds 1 and leaves every other fuse unchanged.

After a program operation the block parks in a finished state until an external reset. Reset clears the shadow register and the mode state but keeps every fuse. Once the seal fuse is set, calibration mode can no longer be entered. The fuse contents are always visible on a read-back bus.

The serial input is a valid/ready stream of one bit per beat. A beat transfers on a clock edge where `s_valid` and `s_ready` are both high. `s_ready` is high only in calibration mode. A producer that offers a bit while `s_ready` is low must hold that bit, because it has not been taken. There is no other back-pressure: in calibration mode every beat is accepted at once.

Top module: `otp_cal_ctrl`

## Requirements
- R1: Fuses change only on a clock edge where the block is in calibration mode, `pwr_on` is high, the shadow register is aligned and `prog_strobe` is high. Outside calibration mode `otp_rd_data` stays stable.
- R2: A program operation sets exactly the fuses whose shadow cell holds 1. A fuse whose shadow cell holds 0 keeps its value, so an all-zero shadow changes nothing.
- R3: Fuses are set-only. No operation, reset included, clears a fuse that holds 1.
- R4: While the seal fuse (bit 0, also shown on `sealed`) is set, `cal_req` never moves the block into calibration mode.
- R5: Bits are shifted most significant first. The first accepted bit ends up in fuse position NBITS-1 and the last accepted bit in position 0, the seal.
- R6: The shadow register counts as aligned only after NBITS beats have been accepted since reset. A strobe before then has no effect, and the block stays in calibration mode.
- R7: A program operation moves the block into a finished state. In that state `cal_mode` and `s_ready` are low, and `cal_req` and `prog_strobe` are ignored until reset.
- R8: `cal_req` is accepted only once `pwr_on` has been high for at least SETTLE_CYC clock edges. It is ignored one cycle earlier. Dropping `pwr_on` restarts the delay and leaves calibration mode.
- R9: `reprog_flag` pulses high for one cycle, in the cycle after a program operation, when the shadow held a 1 over a fuse that was already 1. That fuse stays 1.
- R10: Reset returns the block to the idle state with an empty shadow register and preserves every fuse value.
- R11: `s_ready` is high exactly while in calibration mode. Bits offered while `s_ready` is low are not taken and do not count toward alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; fuses are kept |
| pwr_on | input | 1 | High when the block is out of power-down |
| cal_req | input | 1 | Request to enter calibration mode |
| s_valid | input | 1 | Serial bit valid |
| s_ready | output | 1 | Serial bit accepted this cycle if valid |
| s_data | input | 1 | Serial bit value |
| prog_strobe | input | 1 | Program event, stands in for the programming voltage |
| cal_mode | output | 1 | Block is in calibration mode |
| sealed | output | 1 | Seal fuse is set |
| reprog_flag | output | 1 | One-cycle pulse: a program targeted an already-set fuse |
| otp_rd_data | output | NBITS | Fuse contents |

## Verification
The bench checks the exact settling boundary. A request one cycle early must be refused and one exactly on time must be taken, so a counter that is off by one fails one of the two. It offers bits while not ready and then programs after NBITS-1 accepted bits. A design that took unready beats, or aligned early, would burn fuses and leave calibration mode. A sweep of shift patterns over a growing fuse image catches three faults: reversed bit order, fuses that get cleared, and a wrong overlap flag. Reset between sessions shows that the fuses survive. A final seal session shows that a design which still let `cal_req` through would be reported.

// File: rtl/otp_cal_pkg.sv
package otp_cal_pkg;
  typedef enum logic [1:0] {
    M_IDLE = 2'd0,
    M_CAL  = 2'd1,
    M_DONE = 2'd2
  } cal_state_e;
endpackage

// File: rtl/otp_settle_timer.sv
module otp_settle_timer #(
  parameter int SETTLE_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_on,
  output logic settled
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt_q;

  // Counts edges with power applied, saturating at the limit.
  always_ff @(posedge clk) begin
    if (!rst_n || !pwr_on) begin
      cnt_q <= '0;
    end else if (cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign settled = pwr_on && (cnt_q == LIMIT);
endmodule

// File: rtl/otp_shadow_sreg.sv
module otp_shadow_sreg #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             shift_bit,
  output logic [NBITS-1:0] shadow,
  output logic             aligned
);
  localparam int CW = $clog2(NBITS + 1);
  localparam logic [CW-1:0] FULL = CW'(NBITS);

  logic [NBITS-1:0] sh_q;
  logic [CW-1:0]    cnt_q;

  // New bits enter at position 0; the first bit walks up to NBITS-1.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (shift_en) begin
      sh_q <= {sh_q[NBITS-2:0], shift_bit};
      if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign shadow  = sh_q;
  assign aligned = (cnt_q == FULL);
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             prog_en,
  input  logic [NBITS-1:0] shadow,
  output logic [NBITS-1:0] cells,
  output logic             overlap
);
  logic [NBITS-1:0] fuse_q;

  // Blank fuses read as zero; no reset path touches them.
  initial fuse_q = '0;

  for (genvar i = 0; i < NBITS; i++) begin : g_fuse
    always_ff @(posedge clk) begin
      if (prog_en && shadow[i]) fuse_q[i] <= 1'b1;
    end
  end

  assign cells   = fuse_q;
  assign overlap = |(fuse_q & shadow);
endmodule

// File: rtl/otp_cal_ctrl.sv
module otp_cal_ctrl
  import otp_cal_pkg::*;
#(
  parameter int NBITS      = 8,
  parameter int SETTLE_CYC = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_on,
  input  logic             cal_req,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic             s_data,
  input  logic             prog_strobe,
  output logic             cal_mode,
  output logic             sealed,
  output logic             reprog_flag,
  output logic [NBITS-1:0] otp_rd_data
);
  localparam int SEAL_POS = 0;

  cal_state_e       mode_q;
  logic             settled_w;
  logic [NBITS-1:0] shadow_w;
  logic             aligned_w;
  logic             overlap_w;
  logic             prog_fire;
  logic             shift_en;
  logic             flag_q;

  otp_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr_on  (pwr_on),
    .settled (settled_w)
  );

  assign s_ready  = (mode_q == M_CAL);
  assign shift_en = s_valid && s_ready;

  otp_shadow_sreg #(.NBITS(NBITS)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .shift_bit (s_data),
    .shadow    (shadow_w),
    .aligned   (aligned_w)
  );

  assign prog_fire = prog_strobe && pwr_on && aligned_w && (mode_q == M_CAL);

  otp_cell_array #(.NBITS(NBITS)) u_cells (
    .clk     (clk),
    .prog_en (prog_fire),
    .shadow  (shadow_w),
    .cells   (otp_rd_data),
    .overlap (overlap_w)
  );

  assign sealed = otp_rd_data[SEAL_POS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_IDLE;
      flag_q <= 1'b0;
    end else begin
      flag_q <= prog_fire && overlap_w;
      unique case (mode_q)
        M_IDLE: if (cal_req && settled_w && !sealed) mode_q <= M_CAL;
        M_CAL: begin
          if (!pwr_on)        mode_q <= M_IDLE;
          else if (prog_fire) mode_q <= M_DONE;
        end
        M_DONE:  mode_q <= M_DONE;
        default: mode_q <= M_IDLE;
      endcase
    end
  end

  assign cal_mode    = (mode_q == M_CAL);
  assign reprog_flag = flag_q;
endmodule

// File: rtl/otp_cal_chk.sv
module otp_cal_chk #(
  parameter int NBITS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cal_mode,
  input logic             sealed,
  input logic             prog_strobe,
  input logic             reprog_flag,
  input logic             settled,
  input logic [1:0]       mode,
  input logic [NBITS-1:0] rd_data,
  input logic [NBITS-1:0] shadow
);
  AST_IDLE_NO_BURN: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_mode |=> $stable(rd_data)); // R1

  AST_SHADOW_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rd_data & ~($past(rd_data) | $past(shadow))) == '0)); // R2

  AST_SET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rd_data & $past(rd_data)) == $past(rd_data))); // R3

  AST_SEAL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (sealed && !cal_mode) |=> !cal_mode); // R4

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |=> (mode == 2'd2)); // R7

  AST_ENTRY_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_mode) |-> $past(settled)); // R8

  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    reprog_flag |-> $past(prog_strobe && cal_mode)); // R9
endmodule

bind otp_cal_ctrl otp_cal_chk #(.NBITS(NBITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cal_mode    (cal_mode),
  .sealed      (sealed),
  .prog_strobe (prog_strobe),
  .reprog_flag (reprog_flag),
  .settled     (settled_w),
  .mode        (mode_q),
  .rd_data     (otp_rd_data),
  .shadow      (shadow_w)
);

// File: tb/otp_cal_ctrl_bench.sv
module otp_cal_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int S = 5;

  logic clk = 1'b0;
  logic rst_n, pwr_on, cal_req, s_valid, s_data, prog_strobe;
  logic s_ready, cal_mode, sealed, reprog_flag;
  logic [N-1:0] otp_rd_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [N-1:0] exp_otp = '0;
  logic [N-1:0] sh;

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_cal_ctrl #(.NBITS(N), .SETTLE_CYC(S)) u_otp_cal_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .cal_req(cal_req),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .prog_strobe(prog_strobe), .cal_mode(cal_mode), .sealed(sealed),
    .reprog_flag(reprog_flag), .otp_rd_data(otp_rd_data)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pwr_on = 1'b0; cal_req = 1'b0;
    s_valid = 1'b0; s_data = 1'b0; prog_strobe = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    sh = '0;
  endtask

  task automatic power_up(input int k);
    pwr_on = 1'b1;
    repeat (k) tick();
  endtask

  task automatic request();
    cal_req = 1'b1; tick(); cal_req = 1'b0;
  endtask

  task automatic shift(input logic b, input bit gap);
    s_valid = 1'b1; s_data = b; tick();
    s_valid = 1'b0;
    sh = {sh[N-2:0], b};
    if (gap) tick();
  endtask

  task automatic pulse_prog();
    prog_strobe = 1'b1; tick(); prog_strobe = 1'b0;
  endtask

  task automatic session(input logic [N-1:0] pat, input int k);
    logic [N-1:0] prev;
    do_reset();
    check(otp_rd_data == exp_otp, "R10 fuses kept over reset", otp_rd_data, exp_otp);
    power_up(S);
    request();
    check(cal_mode == 1'b1, "R8 entry after settle", cal_mode, 1);
    for (int i = N - 1; i >= 0; i--) shift(pat[i], ((i + k) % 3) == 0);
    prev = exp_otp;
    exp_otp = exp_otp | sh;
    pulse_prog();
    check(otp_rd_data == exp_otp, "R5 R2 R3 programmed image", otp_rd_data, exp_otp);
    check(reprog_flag == |(prev & sh), "R9 overlap flag", reprog_flag, |(prev & sh));
    check(cal_mode == 1'b0, "R7 finished after program", cal_mode, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    check(otp_rd_data == '0, "R10 blank after reset", otp_rd_data, 0);
    check(!cal_mode && !s_ready && !sealed && !reprog_flag, "R10 idle outputs",
          {cal_mode, s_ready, sealed, reprog_flag}, 0);

    // R8 boundary: one cycle early is refused, on time is taken
    power_up(S - 1);
    request();
    check(cal_mode == 1'b0, "R8 early request ignored", cal_mode, 0);
    request();
    check(cal_mode == 1'b1, "R8 request on time", cal_mode, 1);
    check(s_ready == 1'b1, "R11 ready in cal mode", s_ready, 1);
    pwr_on = 1'b0; tick();
    check(cal_mode == 1'b0, "R8 power drop leaves cal", cal_mode, 0);
    power_up(S - 1);
    request();
    check(cal_mode == 1'b0, "R8 delay restarted", cal_mode, 0);

    // R11 / R6: unready beats ignored, strobe before alignment ignored
    do_reset();
    s_valid = 1'b1; s_data = 1'b1;
    power_up(S);
    check(s_ready == 1'b0, "R11 not ready when idle", s_ready, 0);
    s_valid = 1'b0;
    request();
    for (int i = 0; i < N - 1; i++) shift(1'b0, 1'b0);
    pulse_prog();
    check(cal_mode == 1'b1, "R6 early strobe no effect", cal_mode, 1);
    check(otp_rd_data == '0, "R6 R11 fuses untouched", otp_rd_data, 0);
    shift(1'b0, 1'b0);
    pulse_prog();
    check(otp_rd_data == '0, "R2 zero shadow burns nothing", otp_rd_data, 0);
    check(cal_mode == 1'b0 && s_ready == 1'b0, "R7 finished state", {cal_mode, s_ready}, 0);
    request();
    check(cal_mode == 1'b0, "R7 request ignored until reset", cal_mode, 0);

    // R5 order, then a sweep of patterns that builds up the fuse image
    session(8'h80, 0);
    check(otp_rd_data == 8'h80, "R5 first bit lands on top", otp_rd_data, 8'h80);
    for (int k = 1; k <= 12; k++) session(N'((k * 45 + 7) & 8'hFE), k);

    // R7: a strobe in the finished state does nothing
    shift(1'b1, 1'b0);
    pulse_prog();
    check(otp_rd_data == exp_otp, "R7 strobe ignored when finished", otp_rd_data, exp_otp);

    // R4: seal last
    session(8'h01, 0);
    check(sealed == 1'b1, "R4 seal set", sealed, 1);
    do_reset();
    power_up(S + 2);
    request();
    check(cal_mode == 1'b0 && s_ready == 1'b0, "R4 sealed blocks entry", {cal_mode, s_ready}, 0);
    check(otp_rd_data == exp_otp, "R3 R10 final image", otp_rd_data, exp_otp);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule